// File: doc/BRIEF.md
# Clock Slip Counter

This block compares a device clock against a reference clock, both sampled by a fast system clock. It reports how far the device clock leads or lags, measured in system-clock ticks. It also keeps a signed tally of whole-cycle slips. Software or a neighbouring block programs the nominal clock period in ticks. It then watches `phase_err` as a time-interval-error reading and `slip_count` as a running balance. When the device runs fast, the balance climbs. When it runs slow, the balance falls. A well-locked device keeps the balance near zero.

A two-state machine controls the tracker. In ACQUIRE the block waits until each clock has shown a rising edge, and it holds the phase at zero. The ACQUIRE-to-TRACK transition fires in the cycle in which the second of the two clocks has shown its first edge. In TRACK the lead is the edge-count difference times the period, plus the tick gap between the latest edges of the two clocks. Whenever the lead would reach one full period in either direction, the block books a slip and folds the phase back by one period. Reset enters ACQUIRE. An asserted `clear` forces the TRACK-to-ACQUIRE transition from either state.

Top module: `clk_slip_monitor`

## Requirements
- R1: Each clock input passes through a `STAGES`-flop synchronizer (default 2). A rising edge on an input first affects `phase_err` or the slip outputs `STAGES`+1 system cycles after the cycle in which it was driven.
- R2: After reset, and after each clear, the block sits in ACQUIRE with `slip_count`=0, `phase_err`=0 and no pulse. It enters TRACK once both clocks have shown a rising edge, and tracking then resumes without further action.
- R3: In TRACK, `phase_err` is the lead of the device clock in ticks. The value is positive when device edges come earlier. With equal periods and the device edge 5 ticks ahead, the reading is exactly +5. In TRACK the value always lies strictly between -period and +period. The count of ticks since a clock's last edge is capped at the period, so a stopped clock yields one slip per period of the other clock.
- R4: When the lead would reach +period, `slip_pulse` is 1 for one cycle with `slip_dir`=1. In the same cycle `slip_count` rises by 1 and `phase_err` is reduced by one period.
- R5: When the lead would reach -period, `slip_pulse` is 1 for one cycle with `slip_dir`=0. In the same cycle `slip_count` falls by 1 and `phase_err` is raised by one period.
- R6: Two clocks with equal periods and aligned edges produce no slip, and `phase_err` stays 0.
- R7: `slip_count` is `CNT_W`-bit two's complement and saturates at +2^(CNT_W-1)-1 and -2^(CNT_W-1). Slips still pulse and still fold the phase while the count is held.
- R8: `clear` zeroes `slip_count` and `phase_err` on the next edge. If a slip would register on that same edge, the clear wins and no pulse appears.
- R9: `slip_dir` is 0 in every cycle in which `slip_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| dut_clk_in | input | 1 | Clock of the device being measured |
| ref_clk_in | input | 1 | Reference clock |
| period_ticks | input | PER_W | Nominal clock period in system ticks (at least 2) |
| clear | input | 1 | Synchronous clear of count and phase; restarts acquisition |
| slip_count | output | CNT_W | Signed, saturating slip balance |
| phase_err | output | PER_W+EDGE_W+2 | Signed lead of the device clock in ticks |
| slip_pulse | output | 1 | One-cycle slip event |
| slip_dir | output | 1 | 1 = device gained a cycle, valid with the pulse |

## Verification
The clear and a slip can land on the same system edge. This matters because the clear must suppress the pulse and leave both the count and the phase at zero. The bench first runs a fast-device scenario from a clean start and notes the sample at which the first slip shows. It then replays the identical scenario and raises `clear` one sample earlier, so that both events fall on the same edge. At the sample where the slip would have appeared, it expects a zero count, zero phase and no pulse. It then expects slips to resume after the block re-acquires.

// File: rtl/csc_pkg.sv
package csc_pkg;
    typedef enum logic [0:0] {
        ST_ACQ   = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;
endpackage

// File: rtl/csc_edge_sync.sv
module csc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

    // R1: a detected edge lasts exactly one cycle
    a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/csc_phase_track.sv
module csc_phase_track
    import csc_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int EDGE_W = 4,
    parameter int PH_W   = PER_W + EDGE_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    dut_rise,
    input  logic                    ref_rise,
    input  logic [PER_W-1:0]        period,
    output logic signed [PH_W-1:0]  phase_err,
    output logic                    slip_up,
    output logic                    slip_dn
);
    localparam int TW = PER_W + 1;

    trk_state_e               state_q, state_d;
    logic signed [EDGE_W-1:0] e_q, e_d, e_step;
    logic [TW-1:0]            cd_q, cr_q, cd_n, cr_n, per_t;
    logic                     seen_d_q, seen_r_q, seen_d_n, seen_r_n;
    logic signed [PH_W-1:0]   ph_q, ph_d, ph_lead, per_s;
    logic                     go_track, active;

    assign per_t = {1'b0, period};
    assign per_s = $signed({{(PH_W-PER_W){1'b0}}, period});

    // tick counters since each clock's last edge, capped at one period
    assign cd_n = dut_rise ? '0 : ((cd_q >= per_t) ? cd_q : cd_q + TW'(1));
    assign cr_n = ref_rise ? '0 : ((cr_q >= per_t) ? cr_q : cr_q + TW'(1));

    assign go_track = (state_q == ST_ACQ) && (seen_d_q || dut_rise) && (seen_r_q || ref_rise);
    assign active   = (state_q == ST_TRACK) || go_track;

    // state transition process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQ:   if (go_track) state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
        endcase
        if (clear) state_d = ST_ACQ;
    end

    // datapath and output process
    always_comb begin
        e_step   = '0;
        if (state_q == ST_TRACK)
            e_step = e_q + $signed({{(EDGE_W-1){1'b0}}, dut_rise})
                         - $signed({{(EDGE_W-1){1'b0}}, ref_rise});
        ph_lead  = PH_W'(e_step) * per_s
                 + $signed({{(PH_W-TW){1'b0}}, cd_n})
                 - $signed({{(PH_W-TW){1'b0}}, cr_n});
        seen_d_n = seen_d_q | dut_rise;
        seen_r_n = seen_r_q | ref_rise;
        slip_up  = 1'b0;
        slip_dn  = 1'b0;
        e_d      = '0;
        ph_d     = '0;
        if (active && !clear) begin
            e_d  = e_step;
            ph_d = ph_lead;
            if (ph_lead >= per_s) begin
                slip_up = 1'b1;
                e_d     = e_step - $signed({{(EDGE_W-1){1'b0}}, 1'b1});
                ph_d    = ph_lead - per_s;
            end else if (ph_lead <= -per_s) begin
                slip_dn = 1'b1;
                e_d     = e_step + $signed({{(EDGE_W-1){1'b0}}, 1'b1});
                ph_d    = ph_lead + per_s;
            end
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_ACQ;
            e_q      <= '0;
            cd_q     <= '0;
            cr_q     <= '0;
            seen_d_q <= 1'b0;
            seen_r_q <= 1'b0;
            ph_q     <= '0;
        end else if (clear) begin
            state_q  <= ST_ACQ;
            e_q      <= '0;
            cd_q     <= '0;
            cr_q     <= '0;
            seen_d_q <= 1'b0;
            seen_r_q <= 1'b0;
            ph_q     <= '0;
        end else begin
            state_q  <= state_d;
            e_q      <= e_d;
            cd_q     <= cd_n;
            cr_q     <= cr_n;
            seen_d_q <= seen_d_n;
            seen_r_q <= seen_r_n;
            ph_q     <= ph_d;
        end
    end

    assign phase_err = ph_q;

    // R2: no phase is reported while acquiring
    a_r2_acq_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQ) |-> (ph_q == '0));
    // R3: tracked phase stays strictly inside one period
    a_r3_phase_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK) |-> ((ph_q < per_s) && (ph_q > -per_s)));
    // R8: clear empties the accumulator on the next edge
    a_r8_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ph_q == '0 && state_q == ST_ACQ));
endmodule

// File: rtl/csc_slip_count.sv
module csc_slip_count #(
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    up,
    input  logic                    dn,
    output logic signed [CNT_W-1:0] count,
    output logic                    pulse,
    output logic                    dir
);
    localparam logic signed [CNT_W-1:0] C_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] C_MIN = {1'b1, {(CNT_W-1){1'b0}}};

    logic signed [CNT_W-1:0] count_q;
    logic                    pulse_q, dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            pulse_q <= 1'b0;
            dir_q   <= 1'b0;
        end else if (clear) begin
            count_q <= '0;
            pulse_q <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            pulse_q <= up | dn;
            dir_q   <= up;
            if (up && count_q != C_MAX)
                count_q <= count_q + CNT_W'(1);
            else if (dn && count_q != C_MIN)
                count_q <= count_q - CNT_W'(1);
        end
    end

    assign count = count_q;
    assign pulse = pulse_q;
    assign dir   = dir_q;

    // R4: a gained cycle moves the balance up by one
    a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !clear && count_q != C_MAX) |=> (count_q == $past(count_q) + CNT_W'(1)));
    // R5: a lost cycle moves the balance down by one
    a_r5_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !clear && count_q != C_MIN) |=> (count_q == $past(count_q) - CNT_W'(1)));
    // R7: the balance holds at its ceiling
    a_r7_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !clear && count_q == C_MAX) |=> (count_q == C_MAX && pulse_q));
    // R8: clear zeroes the balance and blocks the pulse
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0 && !pulse_q));
    // R9: no direction without an event
    a_r9_dir_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_q |-> !dir_q);
endmodule

// File: rtl/clk_slip_monitor.sv
module clk_slip_monitor #(
    parameter int STAGES = 2,
    parameter int PER_W  = 16,
    parameter int CNT_W  = 32,
    parameter int EDGE_W = 4,
    parameter int PH_W   = PER_W + EDGE_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dut_clk_in,
    input  logic                    ref_clk_in,
    input  logic [PER_W-1:0]        period_ticks,
    input  logic                    clear,
    output logic signed [CNT_W-1:0] slip_count,
    output logic signed [PH_W-1:0]  phase_err,
    output logic                    slip_pulse,
    output logic                    slip_dir
);
    localparam int NCLK = 2;

    logic [NCLK-1:0] raw_in;
    logic [NCLK-1:0] rise;
    logic            up, dn;

    assign raw_in = {ref_clk_in, dut_clk_in};

    for (genvar i = 0; i < NCLK; i++) begin : g_sync
        csc_edge_sync #(.STAGES(STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[i]),
            .rise (rise[i])
        );
    end

    csc_phase_track #(.PER_W(PER_W), .EDGE_W(EDGE_W), .PH_W(PH_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .dut_rise (rise[0]),
        .ref_rise (rise[1]),
        .period   (period_ticks),
        .phase_err(phase_err),
        .slip_up  (up),
        .slip_dn  (dn)
    );

    csc_slip_count #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(clear),
        .up   (up),
        .dn   (dn),
        .count(slip_count),
        .pulse(slip_pulse),
        .dir  (slip_dir)
    );
endmodule

// File: tb/clk_slip_monitor_bench.sv
`timescale 1ns/1ps
module clk_slip_monitor_bench;
    localparam int PER_W  = 16;
    localparam int CNT_W  = 6;
    localparam int EDGE_W = 4;
    localparam int PH_W   = PER_W + EDGE_W + 2;

    typedef struct packed {
        int dper; int rper; int pcfg; int roff; int cyc;
        int ecnt; int epul; int edir; int plo;  int phi;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{19, 20, 20,  0, 2090,   5,  5, 1,   1,  19},  // R4 fast device
        '{21, 20, 20,  0, 1470,  -3,  3, 0, -19,  -1},  // R5 slow device
        '{20, 20, 20,  0,  800,   0,  0, 0,   0,   0},  // R6 locked
        '{20, 20, 20, 15,  400,   0,  0, 0,   5,   5},  // R3 fixed 5-tick lead
        '{ 7,  8,  8,  0, 2268,  31, 40, 1,   1,   7},  // R7 ceiling
        '{ 9,  8,  8,  0, 2916, -32, 40, 0,  -7,  -1}   // R7 floor
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    dut_clk_in = 1'b0;
    logic                    ref_clk_in = 1'b0;
    logic [PER_W-1:0]        period_ticks = PER_W'(20);
    logic                    clear = 1'b0;
    logic signed [CNT_W-1:0] slip_count;
    logic signed [PH_W-1:0]  phase_err;
    logic                    slip_pulse;
    logic                    slip_dir;

    int n_chk = 0, n_fail = 0;
    int cur_d = 20, cur_r = 20, dcnt = 0, rcnt = 0;
    int pulses, badd, first_k, first_ph;
    string tags [NV] = '{"R4", "R5", "R6", "R3", "R7", "R7"};

    always #2 clk = ~clk;

    clk_slip_monitor #(.PER_W(PER_W), .CNT_W(CNT_W), .EDGE_W(EDGE_W)) u_clk_slip_monitor (
        .clk(clk), .rst_n(rst_n), .dut_clk_in(dut_clk_in), .ref_clk_in(ref_clk_in),
        .period_ticks(period_ticks), .clear(clear), .slip_count(slip_count),
        .phase_err(phase_err), .slip_pulse(slip_pulse), .slip_dir(slip_dir)
    );

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_inputs();
        dut_clk_in = (dcnt < cur_d / 2);
        ref_clk_in = (rcnt < cur_r / 2);
        dcnt = (dcnt + 1) % cur_d;
        rcnt = (rcnt + 1) % cur_r;
    endtask

    task automatic start_vec(input vec_t v);
        clear = 1'b1;
        dut_clk_in = 1'b0;
        ref_clk_in = 1'b0;
        period_ticks = PER_W'(v.pcfg);
        repeat (5) @(negedge clk);
        cur_d = v.dper; cur_r = v.rper;
        dcnt = 0; rcnt = v.roff;
        clear = 1'b0;
        pulses = 0; badd = 0; first_k = -1; first_ph = -1;
        drive_inputs();
    endtask

    task automatic step(input int i, input int edir);
        @(negedge clk);
        if (slip_pulse) begin
            pulses++;
            if (first_k < 0) first_k = i;
            if (int'(slip_dir) != edir) badd++;
        end else if (slip_dir) begin
            badd++;
        end
        if (first_ph < 0 && phase_err != '0) first_ph = i;
        drive_inputs();
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2 count", slip_count == '0, int'(slip_count), 0);
        chk("R2 phase", phase_err == '0, int'(phase_err), 0);
        chk("R2 pulse", !slip_pulse && !slip_dir, int'(slip_pulse), 0);

        for (int n = 0; n < NV; n++) begin
            start_vec(VECS[n]);
            for (int i = 1; i <= VECS[n].cyc; i++) step(i, VECS[n].edir);
            chk({tags[n], " count"}, int'(slip_count) == VECS[n].ecnt, int'(slip_count), VECS[n].ecnt);
            chk({tags[n], " pulses"}, pulses == VECS[n].epul, pulses, VECS[n].epul);
            chk("R9 dir", badd == 0, badd, 0);
            chk({tags[n], " phase"}, int'(phase_err) >= VECS[n].plo && int'(phase_err) <= VECS[n].phi,
                int'(phase_err), VECS[n].plo);
            if (n == 3) chk("R1 latency", first_ph == 8, first_ph, 8);
            if (n == 4) begin
                // R8: clear while running at the ceiling
                clear = 1'b1;
                step(0, 1);
                clear = 1'b0;
                chk("R8 clear count", slip_count == '0, int'(slip_count), 0);
                chk("R8 clear phase", phase_err == '0, int'(phase_err), 0);
            end
        end

        // R8: clear on the same edge as a slip
        start_vec(VECS[4]);
        for (int i = 1; i <= 200 && first_k < 0; i++) step(i, 1);
        k = first_k;
        chk("R4 first slip seen", k > 1, k, 60);
        start_vec(VECS[4]);
        for (int i = 1; i < k; i++) step(i, 1);
        chk("R8 no early slip", pulses == 0, pulses, 0);
        clear = 1'b1;
        step(k, 1);
        clear = 1'b0;
        chk("R8 collision pulse", pulses == 0 && !slip_pulse, pulses, 0);
        chk("R8 collision count", slip_count == '0, int'(slip_count), 0);
        chk("R8 collision phase", phase_err == '0, int'(phase_err), 0);
        pulses = 0;
        for (int i = 1; i <= 300; i++) step(i, 1);
        chk("R2 reacquire", pulses >= 4, pulses, 5);
        chk("R9 dir after clear", badd == 0, badd, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule